// File: doc/BRIEF.md
# Program interrupt PSW update unit

This unit delivers a program interrupt. One request carries the interruption code, the instruction length and the current PSW mask and address. It also carries any pending PER event, given as an address and a 16-bit code/ATMID word, along with the breaking-event address and the new PSW already fetched for the program class. The unit sorts the interruption code into one of two classes. For a completing code, the saved old-PSW address moves past the faulting instruction. For a nullifying code, it stays on that instruction. When a PER event is pending, the unit merges the PER indication into the stored code.

The unit performs no memory access itself. It emits the values to be saved as a sequence of tagged stores on a valid/ready bus. After the last store is taken, it pulses `done` and presents the new PSW to load. A translation-fault request is delivered with its length forced to 2. An unusable instruction length is reported with `err` instead of being delivered.

Top module: `pgm_int_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Once the request is taken, `req_ready` stays low until the cycle after `done`.
- R2: The effective length is the instruction length, or 2 for a translation fault. If the effective length is not 2, 4 or 6, the unit issues no store. In the cycle after acceptance it raises `done` and `err` together for one cycle.
- R3: The following codes are completing: 0x01–0x09, 0x0A–0x0F, 0x12, 0x13, 0x15, 0x1D, 0x1F, 0x28 and 0x40. For these, the stored old address is the current address plus the effective length, modulo 2^AW.
- R4: Code 0x80 (PER event) advances the stored address by the effective length when bit 8 of the PER code/ATMID is 0. When that bit is 1, the address is left unchanged.
- R5: Every other code stores the current address unchanged. Examples are 0x10 and 0x11.
- R6: When a PER event is pending, the stored code is the input code ORed with 0x80. The PER address and PER code/ATMID stores are then included, and `per_clr` pulses on the handshake of the PER code/ATMID store. With no PER event pending, both PER stores are skipped and `per_clr` stays low.
- R7: On a translation-fault request, the stored length is 2 and the address step uses 2, whatever the `req_ilen` value.
- R8: Stores appear in this order, with these `st_field` codes: length=0, code=1, PER address=2, PER code/ATMID=3, old mask=4, old address=5, breaking-event address=6. Length and code are zero-extended in `st_data`. Each store is held unchanged until `st_ready` is high.
- R9: In the cycle after the breaking-event store is taken, `done` is high for one cycle with `err` low. At that point `load_mask`/`load_addr` equal the request's new PSW.
- R10: After reset, `req_ready` is high and `st_valid`, `done`, `err` and `per_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_code | input | CW | Interruption code |
| req_ilen | input | ILW | Instruction length in bytes |
| req_xlat_fault | input | 1 | Interrupt comes from a translation fault |
| req_psw_mask | input | AW | Current PSW mask |
| req_psw_addr | input | AW | Current PSW address |
| req_per_pending | input | 1 | A PER event is pending |
| req_per_addr | input | AW | Pending PER event address |
| req_per_code | input | PERW | Pending PER code/ATMID |
| req_bea | input | AW | Breaking-event address |
| req_new_mask | input | AW | Program-class new PSW mask |
| req_new_addr | input | AW | Program-class new PSW address |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request taken |
| st_field | output | 3 | Store target code |
| st_data | output | AW | Store value |
| per_clr | output | 1 | Pending PER state consumed |
| done | output | 1 | Delivery finished (one cycle) |
| err | output | 1 | Instruction length unusable, with done |
| load_mask | output | AW | PSW mask to load |
| load_addr | output | AW | PSW address to load |

## Verification
The bench targets the classification edges. These are a code just outside the completing set (0x10, 0x11), the PER code with the nullification bit set and cleared, and a PER event merged onto an ordinary code. A classifier that got any of these wrong would store an old address off by exactly the instruction length. A merge that got them wrong would store a code lacking 0x80, or would drop or invent the two PER stores. The bench also drives a translation fault whose raw length is invalid. A unit that checked the raw length would flag an error there, instead of delivering with length 2. Other cases are raw lengths of 0 and 3, an address that wraps at the top of the range, and a stalling `st_ready`. A unit that advanced on a stalled store would skip or repeat entries in the store sequence.

// File: rtl/pgm_int_pkg.sv
package pgm_int_pkg;

    typedef enum logic [2:0] {
        FLD_ILEN     = 3'd0,
        FLD_CODE     = 3'd1,
        FLD_PER_ADDR = 3'd2,
        FLD_PER_CODE = 3'd3,
        FLD_OLD_MASK = 3'd4,
        FLD_OLD_ADDR = 3'd5,
        FLD_BEA      = 3'd6
    } store_fld_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_DONE  = 2'd2
    } ctl_state_e;

    localparam logic [15:0] CODE_PER_EVENT = 16'h0080;

endpackage

// File: rtl/pgm_code_class.sv
module pgm_code_class #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] code,
    input  logic          per_nullify,
    output logic          advance
);
    import pgm_int_pkg::*;

    always_comb begin
        advance = 1'b0;
        case (code)
            CW'(16'h01), CW'(16'h02), CW'(16'h03), CW'(16'h04),
            CW'(16'h05), CW'(16'h06), CW'(16'h07), CW'(16'h08),
            CW'(16'h09), CW'(16'h0A), CW'(16'h0B), CW'(16'h0C),
            CW'(16'h0D), CW'(16'h0E), CW'(16'h0F), CW'(16'h12),
            CW'(16'h13), CW'(16'h15), CW'(16'h1D), CW'(16'h1F),
            CW'(16'h28), CW'(16'h40):
                advance = 1'b1;
            CW'(CODE_PER_EVENT):
                advance = !per_nullify;
            default:
                advance = 1'b0;
        endcase
    end
endmodule

// File: rtl/pgm_len_addr.sv
module pgm_len_addr #(
    parameter int AW  = 64,
    parameter int ILW = 3
) (
    input  logic [ILW-1:0] ilen,
    input  logic           xlat_fault,
    input  logic           advance,
    input  logic [AW-1:0]  cur_addr,
    output logic [ILW-1:0] len_eff,
    output logic           len_ok,
    output logic [AW-1:0]  old_addr
);
    localparam int PADW = AW - ILW;

    assign len_eff = xlat_fault ? ILW'(2) : ilen;

    always_comb begin
        case (len_eff)
            ILW'(2), ILW'(4), ILW'(6): len_ok = 1'b1;
            default:                   len_ok = 1'b0;
        endcase
    end

    assign old_addr = cur_addr + (advance ? {{PADW{1'b0}}, len_eff} : {AW{1'b0}});
endmodule

// File: rtl/pgm_per_merge.sv
module pgm_per_merge #(
    parameter int CW      = 16,
    parameter int PER_BIT = 7
) (
    input  logic [CW-1:0] code,
    input  logic          per_pending,
    output logic [CW-1:0] code_out
);
    localparam logic [CW-1:0] PER_MASK = CW'(1) << PER_BIT;

    assign code_out = per_pending ? (code | PER_MASK) : code;
endmodule

// File: rtl/pgm_int_unit.sv
module pgm_int_unit #(
    parameter int AW       = 64,
    parameter int CW       = 16,
    parameter int PERW     = 16,
    parameter int ILW      = 3,
    parameter int NULL_BIT = 8,
    parameter int PER_BIT  = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [CW-1:0]   req_code,
    input  logic [ILW-1:0]  req_ilen,
    input  logic            req_xlat_fault,
    input  logic [AW-1:0]   req_psw_mask,
    input  logic [AW-1:0]   req_psw_addr,
    input  logic            req_per_pending,
    input  logic [AW-1:0]   req_per_addr,
    input  logic [PERW-1:0] req_per_code,
    input  logic [AW-1:0]   req_bea,
    input  logic [AW-1:0]   req_new_mask,
    input  logic [AW-1:0]   req_new_addr,
    output logic            st_valid,
    input  logic            st_ready,
    output logic [2:0]      st_field,
    output logic [AW-1:0]   st_data,
    output logic            per_clr,
    output logic            done,
    output logic            err,
    output logic [AW-1:0]   load_mask,
    output logic [AW-1:0]   load_addr
);
    import pgm_int_pkg::*;

    typedef struct packed {
        ctl_state_e      state;
        store_fld_e      idx;
        logic            per;
        logic [ILW-1:0]  ilen;
        logic [CW-1:0]   code;
        logic [AW-1:0]   per_addr;
        logic [PERW-1:0] per_code;
        logic [AW-1:0]   old_mask;
        logic [AW-1:0]   old_addr;
        logic [AW-1:0]   bea;
        logic [AW-1:0]   new_mask;
        logic [AW-1:0]   new_addr;
        logic            done;
        logic            err;
        logic [AW-1:0]   load_mask;
        logic [AW-1:0]   load_addr;
    } regs_t;

    regs_t q, d;

    logic           adv;
    logic [ILW-1:0] len_eff;
    logic           len_ok;
    logic [AW-1:0]  adj_addr;
    logic [CW-1:0]  merged_code;
    logic [2:0]     nxt_idx;

    pgm_code_class #(.CW(CW)) class_i (
        .code        (req_code),
        .per_nullify (req_per_code[NULL_BIT]),
        .advance     (adv)
    );

    pgm_len_addr #(.AW(AW), .ILW(ILW)) len_i (
        .ilen       (req_ilen),
        .xlat_fault (req_xlat_fault),
        .advance    (adv),
        .cur_addr   (req_psw_addr),
        .len_eff    (len_eff),
        .len_ok     (len_ok),
        .old_addr   (adj_addr)
    );

    pgm_per_merge #(.CW(CW), .PER_BIT(PER_BIT)) merge_i (
        .code        (req_code),
        .per_pending (req_per_pending),
        .code_out    (merged_code)
    );

    // Next store slot; the two PER slots are skipped without a pending event.
    always_comb begin
        nxt_idx = q.idx + 3'd1;
        if (!q.per && nxt_idx == FLD_PER_ADDR) begin
            nxt_idx = FLD_OLD_MASK;
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!len_ok) begin
                        d.state = ST_DONE;
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                    end else begin
                        d.state    = ST_STORE;
                        d.idx      = FLD_ILEN;
                        d.per      = req_per_pending;
                        d.ilen     = len_eff;
                        d.code     = merged_code;
                        d.per_addr = req_per_addr;
                        d.per_code = req_per_code;
                        d.old_mask = req_psw_mask;
                        d.old_addr = adj_addr;
                        d.bea      = req_bea;
                        d.new_mask = req_new_mask;
                        d.new_addr = req_new_addr;
                    end
                end
            end
            ST_STORE: begin
                if (st_ready) begin
                    if (q.idx == FLD_BEA) begin
                        d.state     = ST_DONE;
                        d.done      = 1'b1;
                        d.load_mask = q.new_mask;
                        d.load_addr = q.new_addr;
                    end else begin
                        d.idx = store_fld_e'(nxt_idx);
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.idx)
            FLD_ILEN:     st_data = {{(AW-ILW){1'b0}}, q.ilen};
            FLD_CODE:     st_data = {{(AW-CW){1'b0}}, q.code};
            FLD_PER_ADDR: st_data = q.per_addr;
            FLD_PER_CODE: st_data = {{(AW-PERW){1'b0}}, q.per_code};
            FLD_OLD_MASK: st_data = q.old_mask;
            FLD_OLD_ADDR: st_data = q.old_addr;
            default:      st_data = q.bea;
        endcase
    end

    assign req_ready = (q.state == ST_IDLE);
    assign st_valid  = (q.state == ST_STORE);
    assign st_field  = q.idx;
    assign per_clr   = st_valid && st_ready && (q.idx == FLD_PER_CODE);
    assign done      = q.done;
    assign err       = q.err;
    assign load_mask = q.load_mask;
    assign load_addr = q.load_addr;
endmodule

// File: rtl/pgm_int_chk.sv
module pgm_int_chk #(
    parameter int AW  = 64,
    parameter int ILW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [ILW-1:0] req_ilen,
    input logic           req_xlat_fault,
    input logic           st_valid,
    input logic           st_ready,
    input logic [2:0]     st_field,
    input logic [AW-1:0]  st_data,
    input logic           done,
    input logic           err
);
    logic raw_len_ok;
    assign raw_len_ok = (req_ilen == ILW'(2)) || (req_ilen == ILW'(4)) || (req_ilen == ILW'(6));

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid || done) |-> !req_ready);

    assert_bad_len_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_xlat_fault && !raw_len_ok) |=> (done && err && !st_valid));

    assert_store_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_field) && $stable(st_data)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_field == 3'd6) |=> (done && !err));

    assert_err_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
endmodule

bind pgm_int_unit pgm_int_chk #(.AW(AW), .ILW(ILW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_ilen       (req_ilen),
    .req_xlat_fault (req_xlat_fault),
    .st_valid       (st_valid),
    .st_ready       (st_ready),
    .st_field       (st_field),
    .st_data        (st_data),
    .done           (done),
    .err            (err)
);

// File: tb/pgm_int_unit_tb_top.sv
`timescale 1ns/1ps
module pgm_int_unit_tb_top;
    localparam int AW = 64;
    localparam int N  = 13;
    localparam int LIMIT = 4000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic            req_valid, req_ready;
    logic [15:0]     req_code;
    logic [2:0]      req_ilen;
    logic            req_xlat_fault;
    logic [AW-1:0]   req_psw_mask, req_psw_addr;
    logic            req_per_pending;
    logic [AW-1:0]   req_per_addr;
    logic [15:0]     req_per_code;
    logic [AW-1:0]   req_bea, req_new_mask, req_new_addr;
    logic            st_valid, st_ready;
    logic [2:0]      st_field;
    logic [AW-1:0]   st_data;
    logic            per_clr, done, err;
    logic [AW-1:0]   load_mask, load_addr;

    pgm_int_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .req_ilen(req_ilen), .req_xlat_fault(req_xlat_fault),
        .req_psw_mask(req_psw_mask), .req_psw_addr(req_psw_addr),
        .req_per_pending(req_per_pending), .req_per_addr(req_per_addr),
        .req_per_code(req_per_code), .req_bea(req_bea),
        .req_new_mask(req_new_mask), .req_new_addr(req_new_addr),
        .st_valid(st_valid), .st_ready(st_ready), .st_field(st_field),
        .st_data(st_data), .per_clr(per_clr), .done(done), .err(err),
        .load_mask(load_mask), .load_addr(load_addr)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Stimulus table
    logic [15:0]   t_code[N];
    logic [2:0]    t_ilen[N];
    logic          t_xlat[N];
    logic [AW-1:0] t_addr[N];
    logic          t_pp[N];
    logic [15:0]   t_pc[N];
    string         t_tag[N];

    task automatic set_t(input int i, input logic [15:0] c, input logic [2:0] l, input logic x,
                         input logic [AW-1:0] a, input logic pp, input logic [15:0] pc,
                         input string tag);
        t_code[i] = c; t_ilen[i] = l; t_xlat[i] = x; t_addr[i] = a;
        t_pp[i] = pp; t_pc[i] = pc; t_tag[i] = tag;
    endtask

    function automatic bit completes(input logic [15:0] c);
        int list[22] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15,
                         18, 19, 21, 29, 31, 40, 64};
        foreach (list[k]) if (int'(c) == list[k]) return 1'b1;
        return 1'b0;
    endfunction

    logic [2:0]    q_fld[$];
    logic [AW-1:0] q_dat[$];
    string         q_tag[$];
    bit            exp_done, exp_err, nd;
    logic [AW-1:0] exp_lm, exp_la, cur_nm, cur_na;
    string         cur_tag;

    initial begin
        int ri;
        int cyc;
        bit rv;
        set_t(0,  16'h0001, 3'd4, 1'b0, 64'h0000_0000_0000_1000, 1'b0, 16'h0000, "R3");
        set_t(1,  16'h0011, 3'd4, 1'b1, 64'h0000_0000_0000_2000, 1'b0, 16'h0000, "R5");
        set_t(2,  16'h0080, 3'd6, 1'b0, 64'h0000_0000_0000_3000, 1'b1, 16'h0040, "R4");
        set_t(3,  16'h0080, 3'd4, 1'b0, 64'h0000_0000_0000_4000, 1'b1, 16'h0140, "R4");
        set_t(4,  16'h0004, 3'd2, 1'b0, 64'h0000_0000_0000_5000, 1'b1, 16'h0021, "R6");
        set_t(5,  16'h0006, 3'd3, 1'b0, 64'h0000_0000_0000_6000, 1'b0, 16'h0000, "R2");
        set_t(6,  16'h0010, 3'd3, 1'b1, 64'h0000_0000_0000_7000, 1'b0, 16'h0000, "R7");
        set_t(7,  16'h0040, 3'd4, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 16'h0000, "R3");
        set_t(8,  16'h0028, 3'd2, 1'b0, 64'h0000_0000_0000_8000, 1'b0, 16'h0000, "R3");
        set_t(9,  16'h001D, 3'd6, 1'b0, 64'h0000_0000_0000_9000, 1'b0, 16'h0000, "R3");
        set_t(10, 16'h0010, 3'd6, 1'b0, 64'h0000_0000_0000_A000, 1'b1, 16'h0000, "R5");
        set_t(11, 16'h0004, 3'd0, 1'b0, 64'h0000_0000_0000_B000, 1'b0, 16'h0000, "R2");
        set_t(12, 16'h0011, 3'd6, 1'b1, 64'h0000_0000_0000_C000, 1'b0, 16'h0000, "R7");

        rst_n = 1'b0; req_valid = 1'b0; st_ready = 1'b0;
        req_code = '0; req_ilen = '0; req_xlat_fault = 1'b0; req_psw_mask = '0;
        req_psw_addr = '0; req_per_pending = 1'b0; req_per_addr = '0; req_per_code = '0;
        req_bea = '0; req_new_mask = '0; req_new_addr = '0;
        exp_done = 1'b0; exp_err = 1'b0; exp_lm = '0; exp_la = '0;
        cur_nm = '0; cur_na = '0; cur_tag = "";
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10", "req_ready", AW'(req_ready), 1);
        chk(st_valid == 1'b0,  "R10", "st_valid", AW'(st_valid), 0);
        chk(done == 1'b0,      "R10", "done", AW'(done), 0);
        chk(err == 1'b0,       "R10", "err", AW'(err), 0);
        chk(per_clr == 1'b0,   "R10", "per_clr", AW'(per_clr), 0);
        rst_n = 1'b1;

        ri = 0;
        cyc = 0;
        while ((ri < N || q_fld.size() > 0 || exp_done) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            // compare with the model
            chk(st_valid == (q_fld.size() > 0), "R8", "st_valid", AW'(st_valid), AW'(q_fld.size() > 0));
            if (q_fld.size() > 0 && st_valid) begin
                chk(st_field == q_fld[0], q_tag[0], "st_field", AW'(st_field), AW'(q_fld[0]));
                chk(st_data == q_dat[0], q_tag[0], "st_data", st_data, q_dat[0]);
            end
            chk(done == exp_done, "R9", "done", AW'(done), AW'(exp_done));
            if (exp_done) begin
                chk(err == exp_err, exp_err ? "R2" : "R9", "err", AW'(err), AW'(exp_err));
                if (!exp_err) begin
                    chk(load_mask == exp_lm, "R9", "load_mask", load_mask, exp_lm);
                    chk(load_addr == exp_la, "R9", "load_addr", load_addr, exp_la);
                end
            end else begin
                chk(err == 1'b0, "R2", "err idle", AW'(err), 0);
            end
            chk(req_ready == (q_fld.size() == 0 && !exp_done), "R1", "req_ready",
                AW'(req_ready), AW'(q_fld.size() == 0 && !exp_done));

            // drive this cycle
            st_ready = (cyc % 3) != 0;
            rv = (ri < N) && (q_fld.size() == 0) && !exp_done;
            req_valid = rv;
            if (rv) begin
                req_code        = t_code[ri];
                req_ilen        = t_ilen[ri];
                req_xlat_fault  = t_xlat[ri];
                req_psw_mask    = 64'h0705_0000_8000_0000 ^ AW'(ri);
                req_psw_addr    = t_addr[ri];
                req_per_pending = t_pp[ri];
                req_per_addr    = 64'h0000_00AB_0000_0000 | AW'(ri * 16);
                req_per_code    = t_pc[ri];
                req_bea         = 64'h0000_0000_00BE_0000 | AW'(ri);
                req_new_mask    = 64'h0400_0000_8000_0000 | AW'(ri);
                req_new_addr    = 64'h0000_0000_0001_0000 + AW'(ri * 256);
            end
            #1;
            chk(per_clr == (q_fld.size() > 0 && st_ready && q_fld[0] == 3'd3), "R6", "per_clr",
                AW'(per_clr), AW'(q_fld.size() > 0 && st_ready && q_fld[0] == 3'd3));

            // predict the next cycle
            nd = 1'b0;
            if (q_fld.size() > 0 && st_ready) begin
                void'(q_fld.pop_front());
                void'(q_dat.pop_front());
                void'(q_tag.pop_front());
                if (q_fld.size() == 0) begin
                    nd = 1'b1; exp_err = 1'b0; exp_lm = cur_nm; exp_la = cur_na;
                end
            end
            if (rv) begin
                logic [2:0]    le;
                bit            adv;
                logic [AW-1:0] oa;
                logic [15:0]   sc;
                le  = req_xlat_fault ? 3'd2 : req_ilen;
                cur_tag = t_tag[ri];
                if (!(le == 3'd2 || le == 3'd4 || le == 3'd6)) begin
                    nd = 1'b1; exp_err = 1'b1;
                end else begin
                    adv = completes(req_code) || (req_code == 16'h0080 && !req_per_code[8]);
                    oa  = req_psw_addr + (adv ? AW'(le) : AW'(0));
                    sc  = req_per_pending ? (req_code | 16'h0080) : req_code;
                    q_fld.push_back(3'd0); q_dat.push_back(AW'(le));
                    q_tag.push_back(req_xlat_fault ? "R7" : "R8");
                    q_fld.push_back(3'd1); q_dat.push_back(AW'(sc)); q_tag.push_back("R6");
                    if (req_per_pending) begin
                        q_fld.push_back(3'd2); q_dat.push_back(req_per_addr); q_tag.push_back("R6");
                        q_fld.push_back(3'd3); q_dat.push_back(AW'(req_per_code)); q_tag.push_back("R6");
                    end
                    q_fld.push_back(3'd4); q_dat.push_back(req_psw_mask); q_tag.push_back("R8");
                    q_fld.push_back(3'd5); q_dat.push_back(oa); q_tag.push_back(cur_tag);
                    q_fld.push_back(3'd6); q_dat.push_back(req_bea); q_tag.push_back("R8");
                    cur_nm = req_new_mask; cur_na = req_new_addr;
                end
                ri++;
            end
            exp_done = nd;
        end

        if (cyc >= LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, LIMIT);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule